// File: doc/BRIEF.md
# IO Virtual Address Translator

This block turns a DMA virtual address from a bus-master device into a physical address. For each request it reads one page-table entry from memory, checks the entry's permission flags, and then either hands the translated piece onward or records a fault. The page-table base and the mask that selects the mapping window come from a register bank outside the block. Both are held steady while a request is in flight.

A request carries an address, a write flag and a byte length. If the request spans 4 KB page boundaries, the block cuts it into per-page pieces and looks up a fresh entry for each one. The block caches nothing, so every page costs one memory read.

The block has three streaming interfaces, each using valid/ready: the request port, the entry-read port and the translated-piece port. A transfer takes place on a clock edge where valid and ready are both high. Once valid is raised it stays high, with its payload unchanged, until ready is seen. The entry response has no ready signal, and the block always takes it while it is waiting for one. The request port offers ready only when the block is idle.

Top module: `iova_xlate`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `pte_rd_valid` and `xl_valid` are low, `req_ready` is high, and `flt_status` and `flt_addr` are zero.
- R2: The entry-read address is `(cfg_base << 4) + (((va & ~cfg_win) >> 10) with bits 1:0 cleared)`, computed on 32 bits. Here `va` is the address of the current piece.
- R3: A piece's physical address is `{1'b0, entry[26:8], va[11:0]}`. `xl_write` repeats the request's write flag. Entry bits 7 and 0 have no effect.
- R4: An entry with bit 1 clear aborts the request with a one-cycle `fault` pulse, and no piece is emitted for that page. `flt_status` then reads 32'hC082_0000 for a write. For a read it also has bit 18 set, giving 32'hC086_0000.
- R5: A write whose entry has bit 2 clear faults in the same way as R4. A read ignores bit 2.
- R6: On a fault, `flt_addr` takes the faulting piece's address with bits 11:0 cleared. `flt_status` and `flt_addr` keep their values until the next fault.
- R7: A request is split into pieces that never cross a 4 KB boundary, each with its own entry read and in address order. A piece's length is the smaller of the bytes left and the bytes to the end of its page. `xl_last` marks the final piece.
- R8: `busy` is high from the cycle after acceptance until the cycle in which `done` or `fault` pulses. While busy, `req_ready` is low and a presented request is ignored. `done` and `fault` never pulse together.
- R9: `pte_rd_valid` with its address, and `xl_valid` with its payload, stay unchanged while the matching ready is low.
- R10: A zero-length request is accepted and pulses `done` one cycle later. It makes no entry read and emits no piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken (idle only) |
| req_addr | input | 32 | DMA virtual address |
| req_write | input | 1 | 1 = write transfer |
| req_len | input | LEN_W | Length in bytes |
| cfg_base | input | 32 | Page-table base register |
| cfg_win | input | 32 | Window-start mask (high bits set) |
| pte_rd_valid | output | 1 | Entry read request |
| pte_rd_ready | input | 1 | Memory accepts the entry read |
| pte_rd_addr | output | 32 | Entry byte address |
| pte_rsp_valid | input | 1 | Entry data returned |
| pte_rsp_data | input | 32 | Entry value |
| xl_valid | output | 1 | Translated piece offered |
| xl_ready | input | 1 | Downstream takes the piece |
| xl_paddr | output | 32 | Physical address of the piece |
| xl_len | output | LEN_W | Piece length in bytes |
| xl_write | output | 1 | Write flag of the piece |
| xl_last | output | 1 | Final piece of the request |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle pulse: request completed |
| fault | output | 1 | One-cycle pulse: request aborted |
| flt_status | output | 32 | Fault syndrome |
| flt_addr | output | 32 | Page-aligned faulting address |

## Verification
A corrupted running address or remaining count shows up at the entry-read port one piece later as a wrong entry address. It also shows up at once as a piece length that breaks the page bound. A control state that is stuck or skips a step shows within a few cycles: a missing or extra entry read, a piece without a lookup, or a `done` or `fault` that never comes or comes early. The monitor catches each of these against its queued expectations. A wrong latched write flag shows on `xl_write`, and as a missing or spurious fault on a page that is read-only.

// File: rtl/iova_pkg.sv
package iova_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_W   = 12;
  localparam int PPN_LO   = 8;
  localparam int PPN_HI   = 26;
  localparam int FLAG_VLD = 1;
  localparam int FLAG_WR  = 2;
  localparam int IDX_SHR  = PAGE_W - 2;
  localparam int BASE_SHL = 4;

  // error + late error + address-valid, reserved nibble = 8
  localparam logic [ADDR_W-1:0] SYND_BASE = 32'hC082_0000;
  localparam logic [ADDR_W-1:0] SYND_RD   = 32'h0004_0000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EMIT
  } xl_state_e;
endpackage

// File: rtl/iova_pte_addr.sv
module iova_pte_addr
  import iova_pkg::*;
(
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] win_i,
  input  logic [ADDR_W-1:0] va_i,
  output logic [ADDR_W-1:0] ent_o
);
  logic [ADDR_W-1:0] in_win;
  logic [ADDR_W-1:0] idx;

  assign in_win = va_i & ~win_i;
  assign idx    = in_win >> IDX_SHR;
  assign ent_o  = (base_i << BASE_SHL) + {idx[ADDR_W-1:2], 2'b00};
endmodule

// File: rtl/iova_piece.sv
module iova_piece
  import iova_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [PAGE_W-1:0] off_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              last_o
);
  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1) << PAGE_W;

  logic [LEN_W-1:0] room;

  assign room   = PAGE_BYTES - LEN_W'(off_i);
  assign last_o = (rem_i <= room);
  assign len_o  = last_o ? rem_i : room;
endmodule

// File: rtl/iova_fault_rec.sv
module iova_fault_rec
  import iova_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] va_i,
  output logic [ADDR_W-1:0] status_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      addr_o   <= '0;
    end else if (cap_i) begin
      status_o <= SYND_BASE | (wr_i ? '0 : SYND_RD);
      addr_o   <= {va_i[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
    end
  end

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(status_o) && $stable(addr_o))); // R6
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iova_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_win,
  output logic              pte_rd_valid,
  input  logic              pte_rd_ready,
  output logic [ADDR_W-1:0] pte_rd_addr,
  input  logic              pte_rsp_valid,
  input  logic [31:0]       pte_rsp_data,
  output logic              xl_valid,
  input  logic              xl_ready,
  output logic [ADDR_W-1:0] xl_paddr,
  output logic [LEN_W-1:0]  xl_len,
  output logic              xl_write,
  output logic              xl_last,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] flt_status,
  output logic [ADDR_W-1:0] flt_addr
);
  localparam int PPN_W = PPN_HI - PPN_LO + 1;
  localparam int PAD_W = ADDR_W - PPN_W - PAGE_W;

  xl_state_e         state;
  logic [ADDR_W-1:0] cur_va;
  logic [LEN_W-1:0]  rem_q;
  logic              wr_q;
  logic [ADDR_W-1:0] pa_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_q;
  logic              done_q;
  logic              fault_q;

  logic [LEN_W-1:0]  nxt_len;
  logic              nxt_last;
  logic              ent_ok;
  logic              flt_cap;

  iova_pte_addr u_ent (
    .base_i (cfg_base),
    .win_i  (cfg_win),
    .va_i   (cur_va),
    .ent_o  (pte_rd_addr)
  );

  iova_piece #(.LEN_W(LEN_W)) u_piece (
    .off_i  (cur_va[PAGE_W-1:0]),
    .rem_i  (rem_q),
    .len_o  (nxt_len),
    .last_o (nxt_last)
  );

  assign ent_ok  = pte_rsp_data[FLAG_VLD] && (!wr_q || pte_rsp_data[FLAG_WR]);
  assign flt_cap = (state == ST_WAIT) && pte_rsp_valid && !ent_ok;

  iova_fault_rec u_frec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_i    (flt_cap),
    .wr_i     (wr_q),
    .va_i     (cur_va),
    .status_o (flt_status),
    .addr_o   (flt_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_va  <= '0;
      rem_q   <= '0;
      wr_q    <= 1'b0;
      pa_q    <= '0;
      len_q   <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_va <= req_addr;
            rem_q  <= req_len;
            wr_q   <= req_write;
            if (req_len == '0) done_q <= 1'b1;
            else               state  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (pte_rd_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (pte_rsp_valid) begin
            if (ent_ok) begin
              pa_q   <= {{PAD_W{1'b0}}, pte_rsp_data[PPN_HI:PPN_LO], cur_va[PAGE_W-1:0]};
              len_q  <= nxt_len;
              last_q <= nxt_last;
              state  <= ST_EMIT;
            end else begin
              fault_q <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        ST_EMIT: begin
          if (xl_ready) begin
            cur_va <= cur_va + ADDR_W'(len_q);
            rem_q  <= rem_q - len_q;
            if (last_q) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state  <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign busy         = (state != ST_IDLE);
  assign pte_rd_valid = (state == ST_FETCH);
  assign xl_valid     = (state == ST_EMIT);
  assign xl_paddr     = pa_q;
  assign xl_len       = len_q;
  assign xl_write     = wr_q;
  assign xl_last      = last_q;
  assign done         = done_q;
  assign fault        = fault_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_rd_valid && !pte_rd_ready) |=> (pte_rd_valid && $stable(pte_rd_addr))); // R9
  AST_XL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !xl_ready) |=> (xl_valid && $stable(xl_paddr) && $stable(xl_len) && $stable(xl_last))); // R9
  AST_PIECE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> (({{(ADDR_W-PAGE_W){1'b0}}, xl_paddr[PAGE_W-1:0]} + ADDR_W'(xl_len))
                  <= (ADDR_W'(1) << PAGE_W))); // R7
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R8
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!busy && req_ready)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pte_rd_valid && !xl_valid)); // R8
  AST_FAULT_SYND: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (flt_status[31] && flt_status[30] && flt_status[17] && flt_status[23:20] == 4'd8)); // R4
endmodule

// File: tb/iova_xlate_tb.sv
module iova_xlate_tb;
  localparam int LEN_W = 16;

  typedef struct {
    logic [31:0]      pa;
    logic [LEN_W-1:0] len;
    logic             wr;
    logic             last;
  } piece_t;

  typedef struct {
    logic        flt;
    logic [31:0] st;
    logic [31:0] ad;
  } end_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [31:0]      req_addr = '0;
  logic             req_write = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [31:0]      cfg_base = 32'h0010_0000;
  logic [31:0]      cfg_win  = 32'hFF00_0000;
  logic             pte_rd_valid;
  logic             pte_rd_ready = 1'b0;
  logic [31:0]      pte_rd_addr;
  logic             pte_rsp_valid = 1'b0;
  logic [31:0]      pte_rsp_data = '0;
  logic             xl_valid;
  logic             xl_ready = 1'b0;
  logic [31:0]      xl_paddr;
  logic [LEN_W-1:0] xl_len;
  logic             xl_write;
  logic             xl_last;
  logic             busy, done, fault;
  logic [31:0]      flt_status, flt_addr;

  iova_xlate #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_len(req_len),
    .cfg_base(cfg_base), .cfg_win(cfg_win),
    .pte_rd_valid(pte_rd_valid), .pte_rd_ready(pte_rd_ready), .pte_rd_addr(pte_rd_addr),
    .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data),
    .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_paddr(xl_paddr), .xl_len(xl_len),
    .xl_write(xl_write), .xl_last(xl_last),
    .busy(busy), .done(done), .fault(fault),
    .flt_status(flt_status), .flt_addr(flt_addr)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ends_seen = 0;
  piece_t piece_q[$];
  logic [31:0] ent_q[$];
  end_t end_q[$];
  logic [31:0] pte_mem [logic [31:0]];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ent_of(input logic [31:0] va);
    logic [31:0] idx;
    idx = (va & ~cfg_win) >> 10;
    return (cfg_base << 4) + (idx & 32'hFFFF_FFFC);
  endfunction

  function automatic logic [31:0] pte_get(input logic [31:0] a);
    if (pte_mem.exists(a)) return pte_mem[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] mk_pte(input logic [18:0] ppn, input logic [7:0] flags);
    return {5'd0, ppn, flags};
  endfunction

  // driver: queues expectations, then offers the request
  task automatic send(input logic [31:0] va, input logic [LEN_W-1:0] len, input logic wr, input bit poke);
    logic [31:0] v;
    logic [LEN_W-1:0] r, room, l;
    logic [31:0] p, e;
    end_t ed;
    piece_t pc;
    int target;
    v = va;
    r = len;
    if (r == '0) begin
      ed.flt = 1'b0; ed.st = '0; ed.ad = '0;
      end_q.push_back(ed);
    end
    while (r != '0) begin
      room = 16'd4096 - {4'd0, v[11:0]};
      l = (r <= room) ? r : room;
      e = ent_of(v);
      ent_q.push_back(e);
      p = pte_get(e);
      if (!p[1] || (wr && !p[2])) begin
        ed.flt = 1'b1;
        ed.st = 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000);
        ed.ad = {v[31:12], 12'h000};
        end_q.push_back(ed);
        break;
      end
      pc.pa = {1'b0, p[26:8], v[11:0]};
      pc.len = l;
      pc.wr = wr;
      pc.last = (r <= room);
      piece_q.push_back(pc);
      v = v + {16'd0, l};
      r = r - l;
      if (r == '0) begin
        ed.flt = 1'b0; ed.st = '0; ed.ad = '0;
        end_q.push_back(ed);
      end
    end
    target = ends_seen + 1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_len = len; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        if (!busy) break;
        req_valid = 1'b1; req_addr = 32'hFF00_0000; req_len = 16'd8; req_write = 1'b0;
        chk("R8", "req_ready while busy", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (ends_seen < target) @(negedge clk);
  endtask

  // monitor and memory model, all on the falling edge
  initial begin
    int cyc;
    int rsp_cnt;
    logic [31:0] pend;
    piece_t pc;
    end_t ed;
    cyc = 0;
    rsp_cnt = -1;
    pend = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cyc++;
        pte_rsp_valid = 1'b0;
        if (rsp_cnt == 0) begin
          pte_rsp_valid = 1'b1;
          pte_rsp_data = pte_get(pend);
          rsp_cnt = -1;
        end else if (rsp_cnt > 0) begin
          rsp_cnt--;
        end
        pte_rd_ready = (cyc % 3) != 0;
        if (pte_rd_valid && pte_rd_ready) begin
          if (ent_q.size() == 0) begin
            chk("R7", "unexpected entry read", pte_rd_addr, 32'hxxxx_xxxx);
          end else begin
            chk("R2", "entry address", pte_rd_addr, ent_q.pop_front());
          end
          pend = pte_rd_addr;
          rsp_cnt = 1;
        end
        xl_ready = (cyc % 4) != 1;  // stalls exercise R9
        if (xl_valid && xl_ready) begin
          if (piece_q.size() == 0) begin
            chk("R4", "unexpected piece", xl_paddr, 32'hxxxx_xxxx);
          end else begin
            pc = piece_q.pop_front();
            chk("R3", "physical address", xl_paddr, pc.pa);
            chk("R7", "piece length", {16'd0, xl_len}, {16'd0, pc.len});
            chk("R7", "last flag", {31'd0, xl_last}, {31'd0, pc.last});
            chk("R3", "write flag", {31'd0, xl_write}, {31'd0, pc.wr});
          end
        end
        if (done || fault) begin
          if (end_q.size() == 0) begin
            chk("R8", "unexpected end pulse", {30'd0, done, fault}, 32'd0);
          end else begin
            ed = end_q.pop_front();
            chk("R8", "fault vs done", {31'd0, fault}, {31'd0, ed.flt});
            if (ed.flt) begin
              chk("R4", "fault status", flt_status, ed.st);
              chk("R6", "fault address", flt_addr, ed.ad);
            end
          end
          ends_seen++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // page k of the 16 MB window sits at entry 0x0100_0000 + 4k
    pte_mem[32'h0100_0000] = mk_pte(19'h12345, 8'h82);
    pte_mem[32'h0100_0004] = mk_pte(19'h00001, 8'h06);
    pte_mem[32'h0100_0008] = mk_pte(19'h7FFFF, 8'h07);
    pte_mem[32'h0100_000C] = mk_pte(19'h00100, 8'h06);
    pte_mem[32'h0100_0010] = mk_pte(19'h00200, 8'h06);
    pte_mem[32'h0100_0018] = mk_pte(19'h55555, 8'h02);
    pte_mem[32'h0100_001C] = mk_pte(19'h0ABCD, 8'h06);
    pte_mem[32'h0100_48D0] = mk_pte(19'h1F00F, 8'h02);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "entry read valid", {31'd0, pte_rd_valid}, 32'd0);
    chk("R1", "piece valid", {31'd0, xl_valid}, 32'd0);
    chk("R1", "end pulses", {30'd0, done, fault}, 32'd0);
    chk("R1", "fault status", flt_status, 32'd0);
    chk("R1", "fault address", flt_addr, 32'd0);

    send(32'hFF00_0123, 16'd16, 1'b0, 1'b0);     // R3 read, extra flag bits set
    send(32'hFF00_1FF0, 16'd16, 1'b1, 1'b0);     // R7 ends exactly at page end
    send(32'hFF00_2FF0, 16'h2010, 1'b1, 1'b0);   // R7 three pieces
    send(32'hFF00_5010, 16'd64, 1'b0, 1'b0);     // R4 invalid entry, read
    send(32'hFF00_6000, 16'd4, 1'b1, 1'b0);      // R5 write to read-only
    send(32'hFF00_6100, 16'd8, 1'b0, 1'b0);      // R5 read of read-only works
    send(32'hFF00_7800, 16'h1000, 1'b1, 1'b0);   // R6 fault on second page
    send(32'hFF00_0000, 16'd0, 1'b0, 1'b0);      // R10 zero length
    chk("R6", "status held", flt_status, 32'hC082_0000);
    chk("R6", "address held", flt_addr, 32'hFF00_8000);
    send(32'hFF00_2F00, 16'h1200, 1'b0, 1'b1);   // R8 requests ignored while busy
    cfg_win = 32'hF000_0000;
    send(32'hF123_4567, 16'd32, 1'b0, 1'b0);     // R2 other window size
    cfg_win = 32'hFF00_0000;

    repeat (4) @(negedge clk);
    chk("R8", "leftover pieces", piece_q.size(), 32'd0);
    chk("R8", "leftover entry reads", ent_q.size(), 32'd0);
    chk("R8", "leftover ends", end_q.size(), 32'd0);
    chk("R8", "idle at end", {31'd0, busy}, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule